// File: doc/BRIEF.md
# Prioritized Interrupt Controller with In-Service Tracking

This block gathers N interrupt inputs for one processor and raises a single normal interrupt request when the most urgent eligible source is more urgent than what the processor is already doing. Each source has its own configuration word, set through a simple register write port. That word holds a vector, a priority, a mask bit, a sensitivity bit and two routing bits. A task-priority register lets software raise a floor: a source is signalled only if its priority is strictly above that floor and strictly above the highest priority now in service.

Software takes an interrupt by reading the acknowledge register. The read returns the latched vector, drops the request and marks the source in service. A write to the end-of-interrupt register retires the most urgent in-service entry, so lower-priority sources can be recognised again. Level-sensitive sources can instead be routed to a separate critical output, which bypasses arbitration and acknowledge.

Register addresses are `AW = log2(N)+1` bits wide, and N must be a power of two, at least 4. When the top address bit is clear, the low bits pick a source. When it is set, the two low bits pick a control register: 0 is task priority, 1 is the spurious vector, 2 is end of interrupt (write only) and 3 is acknowledge (read only). `rd_data` is registered and is updated on the clock edge where `rd_en` is high.

Top module: `prio_intc`

## Requirements
- R1: A source word holds the vector in bits [7:0], priority in [11:8], mask in bit 16, level sensitivity in bit 17, normal routing in bit 20 and critical routing in bit 21. Reading the source address returns that word, with bit 31 set while the source is pending or in service.
- R2: An edge-sensitive source (bit 17 clear) sets a pending flag on a rising input, held until it is acknowledged. A level-sensitive source is pending exactly while its input is high.
- R3: The candidate is the highest-priority source that is pending, unmasked, routed to the normal output and not in service. Among equal priorities the lowest-numbered source wins.
- R4: `irq_o` is high only when the candidate priority is strictly greater than the task priority and strictly greater than the highest in-service priority (0 when none is in service). It follows a level input one cycle later and an edge input two cycles later.
- R5: An acknowledge read while `irq_o` is high returns the candidate's vector, clears `irq_o` on the next cycle, marks that source in service and clears its edge pending flag.
- R6: An acknowledge read while `irq_o` is low returns the programmed spurious vector and changes no pending or in-service state.
- R7: An end-of-interrupt write clears only the highest-priority in-service entry, after which waiting lower-priority sources become eligible again.
- R8: A masked source never raises `irq_o`. Clearing its mask lets it compete again.
- R9: A source with critical routing and level sensitivity drives `crit_irq_o` high one cycle after its unmasked input is high, and never `irq_o`. An edge-sensitive source with critical routing drives neither output.
- R10: Reset (`rst_n` low) clears all pending and in-service state, sets the task priority to 15, sets the spurious vector to 0xFF and masks every source with all its other fields at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N | Interrupt inputs, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (acknowledge when it addresses code 3) |
| rd_addr | input | AW | Register read address |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| crit_irq_o | output | 1 | Critical interrupt request |

## Verification
The bench builds the block with its defaults: N = 8 sources, 4-bit priorities and 8-bit vectors, which give addresses 8 to 11 for the control registers. Eight sources are enough to nest two priorities, to tie two sources at the same priority, and still to leave spare sources for masking and critical routing. Together these reach every arbitration, acknowledge and end-of-interrupt path. The 4-bit priority field allows the task priority to be placed exactly at, and one below, a source's priority, which checks the strict comparison at its boundary.

// File: rtl/prio_intc_pkg.sv
// Package: shared register field positions and control-register codes.
// Assumes a 32-bit register data path and vector/priority widths of at most 8.
package prio_intc_pkg;
    localparam int DW        = 32;
    localparam int F_VEC     = 0;
    localparam int F_PRI     = 8;
    localparam int F_MASK    = 16;
    localparam int F_LEVEL   = 17;
    localparam int F_NORM    = 20;
    localparam int F_CRIT    = 21;
    localparam int F_ACTIVE  = 31;

    typedef enum logic [1:0] {
        REG_TPR  = 2'd0,
        REG_SPUR = 2'd1,
        REG_EOI  = 2'd2,
        REG_ACK  = 2'd3
    } ctl_reg_e;
endpackage

// File: rtl/prio_intc_sel.sv
// Priority selector: finds the highest-priority valid entry; on ties the
// lowest index wins. Purely combinational; assumes N >= 2.
module prio_intc_sel #(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][PW-1:0] prio,
    output logic                 found,
    output logic [IW-1:0]        idx,
    output logic [PW-1:0]        best
);
    // Linear scan, strict compare keeps the earliest index on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && (!found || prio[i] > best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/prio_intc_srcbank.sv
// Source bank: per-source configuration registers, edge capture and pending
// derivation, plus the critical output. Assumes one config write per cycle.
module prio_intc_srcbank
    import prio_intc_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int VW = 8,
    parameter int IW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         irq_in,
    input  logic                 cfg_we,
    input  logic [IW-1:0]        cfg_idx,
    input  logic [DW-1:0]        cfg_wdata,
    input  logic [N-1:0]         pend_clr,
    output logic [N-1:0]         pend,
    output logic [N-1:0]         mask,
    output logic [N-1:0]         level,
    output logic [N-1:0]         to_norm,
    output logic [N-1:0]         to_crit,
    output logic [N-1:0][PW-1:0] prio,
    output logic [N-1:0][VW-1:0] vec,
    output logic                 crit_irq_o
);
    logic [N-1:0] in_prev;
    logic [N-1:0] edge_pend;

    for (genvar g = 0; g < N; g++) begin : g_src
        // Configuration register for this source; reset leaves it masked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec[g]     <= '0;
                prio[g]    <= '0;
                mask[g]    <= 1'b1;
                level[g]   <= 1'b0;
                to_norm[g] <= 1'b0;
                to_crit[g] <= 1'b0;
            end else if (cfg_we && cfg_idx == IW'(g)) begin
                vec[g]     <= cfg_wdata[F_VEC +: VW];
                prio[g]    <= cfg_wdata[F_PRI +: PW];
                mask[g]    <= cfg_wdata[F_MASK];
                level[g]   <= cfg_wdata[F_LEVEL];
                to_norm[g] <= cfg_wdata[F_NORM];
                to_crit[g] <= cfg_wdata[F_CRIT];
            end
        end

        // Rising-edge capture, held until acknowledge clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_prev[g]   <= 1'b0;
                edge_pend[g] <= 1'b0;
            end else begin
                in_prev[g]   <= irq_in[g];
                edge_pend[g] <= (irq_in[g] && !in_prev[g]) || (edge_pend[g] && !pend_clr[g]);
            end
        end

        // Pending view: raw input for level sources, captured flag otherwise.
        assign pend[g] = level[g] ? irq_in[g] : edge_pend[g];
    end

    // Critical output: any unmasked level source routed to it.
    always_ff @(posedge clk) begin
        if (!rst_n) crit_irq_o <= 1'b0;
        else        crit_irq_o <= |(irq_in & to_crit & level & ~mask);
    end
endmodule

// File: rtl/prio_intc.sv
// Interrupt controller top: register decode, candidate arbitration against
// task priority and in-service priority, acknowledge and end-of-interrupt.
// Assumes N is a power of two and at least 4 (control codes use addr[1:0]).
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int VW = 8,
    parameter int IW = $clog2(N),
    parameter int AW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data,
    output logic          irq_o,
    output logic          crit_irq_o
);
    logic [N-1:0]         pend, mask, level, to_norm, to_crit, pend_clr;
    logic [N-1:0][PW-1:0] prio;
    logic [N-1:0][VW-1:0] vec;
    logic [N-1:0]         isr, isr_nxt;
    logic [PW-1:0]        tpr;
    logic [VW-1:0]        spur;
    logic                 cand_found, isr_found;
    logic [IW-1:0]        cand_idx, isr_idx, lat_idx;
    logic [PW-1:0]        cand_prio, isr_prio, isr_level, lat_prio;
    logic [VW-1:0]        lat_vec;
    logic                 eligible, ack, eoi, wr_ctl, rd_ctl, take;
    logic [DW-1:0]        cfg_word;
    logic [IW-1:0]        rd_idx;

    assign wr_ctl = wr_addr[AW-1];
    assign rd_ctl = rd_addr[AW-1];
    assign ack    = rd_en && rd_ctl && ctl_reg_e'(rd_addr[1:0]) == REG_ACK;
    assign eoi    = wr_en && wr_ctl && ctl_reg_e'(wr_addr[1:0]) == REG_EOI;
    assign take   = ack && irq_o;
    assign rd_idx = rd_addr[IW-1:0];

    prio_intc_srcbank #(.N(N), .PW(PW), .VW(VW), .IW(IW)) bank_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_we(wr_en && !wr_ctl), .cfg_idx(wr_addr[IW-1:0]), .cfg_wdata(wr_data),
        .pend_clr(pend_clr), .pend(pend), .mask(mask), .level(level),
        .to_norm(to_norm), .to_crit(to_crit), .prio(prio), .vec(vec),
        .crit_irq_o(crit_irq_o)
    );

    prio_intc_sel #(.N(N), .PW(PW), .IW(IW)) cand_sel_i (
        .valid(pend & ~mask & to_norm & ~isr), .prio(prio),
        .found(cand_found), .idx(cand_idx), .best(cand_prio)
    );

    prio_intc_sel #(.N(N), .PW(PW), .IW(IW)) isr_sel_i (
        .valid(isr), .prio(prio),
        .found(isr_found), .idx(isr_idx), .best(isr_prio)
    );

    // Eligibility: candidate must beat both the task floor and in-service level.
    assign isr_level = isr_found ? isr_prio : '0;
    assign eligible  = cand_found && cand_prio > tpr && cand_prio > isr_level;
    assign pend_clr  = take ? (N'(1) << lat_idx) : '0;

    // Request output and latched candidate; acknowledge drops the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o    <= 1'b0;
            lat_idx  <= '0;
            lat_prio <= '0;
            lat_vec  <= '0;
        end else begin
            irq_o <= eligible && !ack;
            if (eligible) begin
                lat_idx  <= cand_idx;
                lat_prio <= cand_prio;
                lat_vec  <= vec[cand_idx];
            end
        end
    end

    // Next in-service set: acknowledge adds, end-of-interrupt retires the top.
    always_comb begin
        isr_nxt = isr;
        if (take) isr_nxt[lat_idx] = 1'b1;
        if (eoi && isr_found) isr_nxt[isr_idx] = 1'b0;
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= isr_nxt;
    end

    // Task priority and spurious vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr  <= '1;
            spur <= '1;
        end else if (wr_en && wr_ctl) begin
            if (ctl_reg_e'(wr_addr[1:0]) == REG_TPR)  tpr  <= wr_data[PW-1:0];
            if (ctl_reg_e'(wr_addr[1:0]) == REG_SPUR) spur <= wr_data[VW-1:0];
        end
    end

    // Readback word for the addressed source, with its activity flag.
    always_comb begin
        cfg_word                 = '0;
        cfg_word[F_VEC +: VW]    = vec[rd_idx];
        cfg_word[F_PRI +: PW]    = prio[rd_idx];
        cfg_word[F_MASK]         = mask[rd_idx];
        cfg_word[F_LEVEL]        = level[rd_idx];
        cfg_word[F_NORM]         = to_norm[rd_idx];
        cfg_word[F_CRIT]         = to_crit[rd_idx];
        cfg_word[F_ACTIVE]       = pend[rd_idx] | isr[rd_idx];
    end

    // Registered read port; acknowledge returns latched or spurious vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (!rd_ctl) begin
                rd_data <= cfg_word;
            end else begin
                case (ctl_reg_e'(rd_addr[1:0]))
                    REG_TPR:  rd_data <= DW'(tpr);
                    REG_SPUR: rd_data <= DW'(spur);
                    REG_ACK:  rd_data <= irq_o ? DW'(lat_vec) : DW'(spur);
                    default:  rd_data <= '0;
                endcase
            end
        end
    end

    a_r4_above_tpr: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> lat_prio > $past(tpr));
    a_r3_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !isr[lat_idx]);
    a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq_o);
    a_r5_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !eoi) |=> $countones(isr) == $past($countones(isr)) + 1);
    a_r6_spurious_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq_o && !eoi) |=> $stable(isr));
    a_r7_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr != '0 && !take) |=> $countones(isr) == $past($countones(isr)) - 1);
endmodule

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
    localparam int CLK_P = 10;
    localparam int N = 8;
    localparam int AW = 4;
    localparam logic [3:0] A_TPR = 4'd8, A_SPUR = 4'd9, A_EOI = 4'd10, A_ACK = 4'd11;
    localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic irq_o, crit_irq_o;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_o(irq_o), .crit_irq_o(crit_irq_o)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [7:0]  src;
        logic        eirq;
        logic        crd;
        logic [31:0] erd;
        logic [3:0]  req;
    } row_t;

    localparam int NROW = 31;
    localparam row_t TBL [NROW] = '{
        '{OP_WR, 4'd2,  32'h0010_0522, 8'h00, 1'b0, 1'b0, 32'h0, 4'd1},   // R1 src2 edge pri5
        '{OP_WR, 4'd5,  32'h0010_0955, 8'h00, 1'b0, 1'b0, 32'h0, 4'd1},   // R1 src5 edge pri9
        '{OP_WR, 4'd6,  32'h0012_0966, 8'h00, 1'b0, 1'b0, 32'h0, 4'd1},   // R1 src6 level pri9
        '{OP_WR, 4'd1,  32'h0010_0711, 8'h00, 1'b0, 1'b0, 32'h0, 4'd1},   // R1 src1 pri7
        '{OP_WR, 4'd3,  32'h0010_0733, 8'h00, 1'b0, 1'b0, 32'h0, 4'd1},   // R1 src3 pri7
        '{OP_WR, A_TPR, 32'd3,         8'h00, 1'b0, 1'b0, 32'h0, 4'd4},   // R4 tpr=3
        '{OP_IDLE, 4'd0, 32'd0,        8'h04, 1'b1, 1'b0, 32'h0, 4'd2},   // R2 edge rise src2
        '{OP_RD, A_ACK, 32'd0,         8'h04, 1'b0, 1'b1, 32'h22, 4'd5},  // R5 ack src2
        '{OP_IDLE, 4'd0, 32'd0,        8'h24, 1'b1, 1'b0, 32'h0, 4'd4},   // R4 nest pri9 over 5
        '{OP_RD, A_ACK, 32'd0,         8'h24, 1'b0, 1'b1, 32'h55, 4'd5},  // R5 ack src5
        '{OP_RD, A_ACK, 32'd0,         8'h24, 1'b0, 1'b1, 32'hFF, 4'd6},  // R6 spurious
        '{OP_WR, A_EOI, 32'd0,         8'h24, 1'b0, 1'b0, 32'h0, 4'd7},   // R7 retire src5
        '{OP_RD, 4'd2,  32'd0,         8'h24, 1'b0, 1'b1, 32'h8010_0522, 4'd7}, // R7 src2 still active
        '{OP_RD, 4'd5,  32'd0,         8'h24, 1'b0, 1'b1, 32'h0010_0955, 4'd7}, // R7 src5 retired
        '{OP_WR, A_EOI, 32'd0,         8'h24, 1'b0, 1'b0, 32'h0, 4'd7},   // R7 retire src2
        '{OP_IDLE, 4'd0, 32'd0,        8'h64, 1'b1, 1'b0, 32'h0, 4'd2},   // R2 level high
        '{OP_RD, A_ACK, 32'd0,         8'h64, 1'b0, 1'b1, 32'h66, 4'd5},  // R5 ack src6
        '{OP_WR, A_EOI, 32'd0,         8'h64, 1'b1, 1'b0, 32'h0, 4'd2},   // R2 level re-requests
        '{OP_IDLE, 4'd0, 32'd0,        8'h24, 1'b0, 1'b0, 32'h0, 4'd2},   // R2 level drop
        '{OP_WR, A_TPR, 32'd9,         8'h04, 1'b0, 1'b0, 32'h0, 4'd4},   // R4 tpr=9
        '{OP_IDLE, 4'd0, 32'd0,        8'h24, 1'b0, 1'b0, 32'h0, 4'd4},   // R4 equal not enough
        '{OP_WR, A_TPR, 32'd8,         8'h24, 1'b1, 1'b0, 32'h0, 4'd4},   // R4 one below fires
        '{OP_RD, A_ACK, 32'd0,         8'h24, 1'b0, 1'b1, 32'h55, 4'd5},  // R5
        '{OP_WR, A_EOI, 32'd0,         8'h24, 1'b0, 1'b0, 32'h0, 4'd7},   // R7
        '{OP_WR, A_TPR, 32'd0,         8'h00, 1'b0, 1'b0, 32'h0, 4'd4},   // R4 tpr=0
        '{OP_IDLE, 4'd0, 32'd0,        8'h0A, 1'b1, 1'b0, 32'h0, 4'd3},   // R3 tie src1/src3
        '{OP_RD, A_ACK, 32'd0,         8'h0A, 1'b0, 1'b1, 32'h11, 4'd3},  // R3 lowest index
        '{OP_WR, A_EOI, 32'd0,         8'h0A, 1'b1, 1'b0, 32'h0, 4'd7},   // R7 src3 now eligible
        '{OP_RD, A_ACK, 32'd0,         8'h0A, 1'b0, 1'b1, 32'h33, 4'd3},  // R3
        '{OP_WR, A_EOI, 32'd0,         8'h0A, 1'b0, 1'b0, 32'h0, 4'd7},   // R7
        '{OP_RD, A_TPR, 32'd0,         8'h00, 1'b0, 1'b1, 32'h0, 4'd4}    // R4 tpr readback
    };

    function automatic logic [31:0] cw(input logic [7:0] v, input logic [3:0] p,
                                       input logic m, input logic l, input logic nr, input logic cr);
        return {10'd0, cr, nr, 2'd0, l, m, 4'd0, p, v};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One operation pulse, then three settle cycles; ends just after a negedge.
    task automatic step(input logic [1:0] op, input logic [3:0] a, input logic [31:0] d,
                        input logic [7:0] s);
        @(negedge clk);
        irq_in  = s;
        wr_en   = (op == OP_WR);
        rd_en   = (op == OP_RD);
        wr_addr = a;
        rd_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R10 irq after reset", 32'(irq_o), 32'd0);
        check("R10 crit after reset", 32'(crit_irq_o), 32'd0);
        step(OP_RD, A_TPR, 0, 8'h00);
        check("R10 tpr max", rd_data, 32'hF);
        step(OP_RD, A_ACK, 0, 8'h00);
        check("R10 spurious default", rd_data, 32'hFF);

        for (int i = 0; i < NROW; i++) begin
            step(TBL[i].op, TBL[i].addr, TBL[i].data, TBL[i].src);
            check($sformatf("R%0d row %0d irq", TBL[i].req, i), 32'(irq_o), 32'(TBL[i].eirq));
            check($sformatf("R9 row %0d crit idle", i), 32'(crit_irq_o), 32'd0);
            if (TBL[i].crd)
                check($sformatf("R%0d row %0d rd", TBL[i].req, i), rd_data, TBL[i].erd);
        end

        // R8: masked level source is ignored, then competes once unmasked.
        step(OP_WR, 4'd4, cw(8'h44, 4'd12, 1'b1, 1'b1, 1'b1, 1'b0), 8'h10);
        check("R8 masked no irq", 32'(irq_o), 32'd0);
        step(OP_RD, A_ACK, 0, 8'h10);
        check("R8 masked ack spurious", rd_data, 32'hFF);
        step(OP_WR, 4'd4, cw(8'h44, 4'd12, 1'b0, 1'b1, 1'b1, 1'b0), 8'h10);
        check("R8 unmasked irq", 32'(irq_o), 32'd1);
        step(OP_RD, A_ACK, 0, 8'h10);
        check("R8 unmasked vector", rd_data, 32'h44);
        step(OP_WR, A_EOI, 0, 8'h00);
        check("R7 all retired", 32'(irq_o), 32'd0);

        // R9: critical routing for level sources only.
        step(OP_WR, 4'd7, cw(8'h77, 4'd3, 1'b0, 1'b1, 1'b0, 1'b1), 8'h80);
        check("R9 crit level", 32'(crit_irq_o), 32'd1);
        check("R9 normal quiet", 32'(irq_o), 32'd0);
        step(OP_IDLE, 4'd0, 0, 8'h00);
        check("R9 crit drops", 32'(crit_irq_o), 32'd0);
        step(OP_WR, 4'd7, cw(8'h77, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1), 8'h80);
        check("R9 crit edge ignored", 32'(crit_irq_o), 32'd0);
        check("R9 edge crit normal quiet", 32'(irq_o), 32'd0);

        // R6: programmed spurious vector.
        step(OP_WR, A_SPUR, 32'h5A, 8'h00);
        step(OP_RD, A_ACK, 0, 8'h00);
        check("R6 programmed spurious", rd_data, 32'h5A);
        step(OP_RD, A_SPUR, 0, 8'h00);
        check("R6 spurious readback", rd_data, 32'h5A);

        // R10: reset mid-run restores defaults.
        do_reset();
        check("R10 irq cleared", 32'(irq_o), 32'd0);
        step(OP_RD, A_TPR, 0, 8'h00);
        check("R10 tpr restored", rd_data, 32'hF);
        step(OP_RD, 4'd2, 0, 8'h00);
        check("R10 source masked", rd_data, 32'h0001_0000);
        step(OP_RD, A_ACK, 0, 8'h00);
        check("R10 spurious restored", rd_data, 32'hFF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule